// File: doc/BRIEF.md
# Nonvolatile Write Sequencer

The sequencer runs one program cycle at a time into a small on-chip nonvolatile data store on behalf of a processor. Software sets an enable bit, checks that the busy status bit is clear, and then issues a write command with an address and a data byte. The block latches both and marks the target word as not valid while its contents change. It then counts ticks of a selectable count clock until a programmable terminal count is reached. When the cycle finishes normally, the word is stored, its valid flag is set, and a one-cycle completion interrupt is raised.

Real-time program length is a system choice. With the chosen count clock, the terminal count must cover at least 3.3 ms. A cycle can be disturbed in four ways: a stop power state, loss of the selected count clock, clearing of the enable bit, or reset. In each of these cases the target word stays invalid and busy falls without an interrupt. The stop state is the exception: the cycle freezes, and the interrupt is raised once the stop state is left. A halt power state has no effect on the cycle.

The controller has three states. In IDLE an accepted command moves it to PROG. In PROG there are four exits: stop moves it to FROZEN; enable clear or clock loss aborts it to IDLE; the final tick completes it to IDLE with the interrupt. In FROZEN, leaving stop wakes it to IDLE with the interrupt.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` reads 2'b00 and `done_irq` is 0.
- R2: A cycle with `ctl_we`=1 loads the enable bit from `ctl_en`. `ctl_rdata` reads {busy, enable}, with busy at bit 1 and enable at bit 0. Busy is 1 for the whole program cycle.
- R3: A command (`cmd_valid`=1) is accepted only when the block is idle and enable is 1. Busy reads 1 from the next cycle. A command refused while disabled changes no stored word.
- R4: A command issued while busy is ignored. The running cycle keeps its latched address and data, and the word at the ignored address is unchanged.
- R5: The target word reads invalid from the cycle after acceptance. A normal completion stores the latched data and sets the word valid.
- R6: A cycle ends on the edge that samples the `prog_tc`-th tick of the selected source; a `prog_tc` of 0 counts as 1. `done_irq` is a one-cycle pulse, and busy reads 0 in that same cycle.
- R7: `cnt_src` selects the tick source: 0 is the main clock, 1 is the timer output, 2 is the subsystem clock, and 3 is no source.
- R8: A `pwr_state` of 1 (halt) during a cycle has no effect, and the cycle completes normally. A `pwr_state` of 0 means run.
- R9: A `pwr_state` of 2 (stop) during a cycle moves it to FROZEN. Busy stays 1 and the target stays invalid. When `pwr_state` leaves 2, busy clears and `done_irq` pulses in the same cycle.
- R10: Writing enable to 0 during PROG aborts the cycle on that edge. Busy clears, no interrupt is raised, and the target stays invalid.
- R11: With source 1 selected, dropping `timer_run` or `timer_oe` during PROG aborts the cycle on that edge, with no interrupt.
- R12: If no selected tick is sampled for `wdog_win` consecutive PROG cycles, the next tickless PROG cycle aborts, with no interrupt.
- R13: Reset during a cycle clears busy and enable, and leaves the target word invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable value written on `ctl_we` |
| ctl_rdata | output | 2 | {busy, enable} |
| cmd_valid | input | 1 | Write command request |
| cmd_addr | input | AW | Command word address |
| cmd_data | input | DW | Command data |
| cnt_src | input | 2 | Count clock source select |
| prog_tc | input | TCW | Terminal tick count of a cycle |
| wdog_win | input | WDW | Tick-loss window in system clocks |
| main_tick | input | 1 | Main-clock count strobe |
| timer_tick | input | 1 | Timer output count strobe |
| timer_run | input | 1 | Timer running |
| timer_oe | input | 1 | Timer output enabled |
| sub_tick | input | 1 | Subsystem-clock count strobe |
| pwr_state | input | 2 | 0 run, 1 halt, 2 stop |
| done_irq | output | 1 | Completion interrupt pulse |
| rd_addr | input | AW | Store read address |
| rd_data | output | DW | Stored word |
| rd_valid | output | 1 | Valid flag of the addressed word |

## Verification
The bench disturbs running cycles from each source: a timer that stops, a timer whose output is disabled, a subsystem clock that goes silent, the empty source, enable clear, stop and reset. A design that kept counting through any of these would complete and mark a corrupted word valid. A design that raised the interrupt on an abort would signal false completion. Overlapping commands and a command issued while disabled are followed by readback of the untouched word, which catches a design that re-latches or invalidates on a refused command. Each completion is compared tick by tick against the terminal count, including a count of 0. That comparison exposes an off-by-one end of cycle or an interrupt that overlaps busy.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_FROZEN = 2'd2
    } prog_state_e;

    localparam logic [1:0] SRC_MAIN  = 2'd0;
    localparam logic [1:0] SRC_TIMER = 2'd1;
    localparam logic [1:0] SRC_SUB   = 2'd2;
    localparam logic [1:0] SRC_NONE  = 2'd3;

    localparam logic [1:0] PWR_RUN  = 2'd0;
    localparam logic [1:0] PWR_HALT = 2'd1;
    localparam logic [1:0] PWR_STOP = 2'd2;

endpackage

// File: rtl/nvm_tick_guard.sv
module nvm_tick_guard
    import nvm_prog_pkg::*;
#(
    parameter int WDW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic [1:0]     src,
    input  logic           main_tick,
    input  logic           timer_tick,
    input  logic           timer_run,
    input  logic           timer_oe,
    input  logic           sub_tick,
    input  logic [WDW-1:0] wdog_win,
    output logic           tick,
    output logic           lost
);
    logic [WDW-1:0] gap_q;
    logic           timer_dead;
    logic           starved;

    // source multiplexer, 3 selects nothing
    always_comb begin
        unique case (src)
            SRC_MAIN:  tick = main_tick;
            SRC_TIMER: tick = timer_tick;
            SRC_SUB:   tick = sub_tick;
            default:   tick = 1'b0;
        endcase
    end

    // tickless cycles seen in PROG, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !active || tick) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign timer_dead = (src == SRC_TIMER) && !(timer_run && timer_oe);
    assign starved    = !tick && (gap_q >= wdog_win);
    assign lost       = active && (timer_dead || starved);

endmodule

// File: rtl/nvm_prog_fsm.sv
module nvm_prog_fsm
    import nvm_prog_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int TCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           cmd_valid,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [DW-1:0]  cmd_data,
    input  logic           en_clear,
    input  logic           tick,
    input  logic           lost,
    input  logic           stop,
    input  logic [TCW-1:0] tc,
    output logic           busy,
    output logic           in_prog,
    output logic           done_irq,
    output logic           accept,
    output logic           commit,
    output logic [AW-1:0]  tgt_addr,
    output logic [DW-1:0]  tgt_data
);
    prog_state_e    state_q, state_d;
    logic [TCW-1:0] cnt_q;
    logic [TCW-1:0] tc_eff;
    logic [TCW:0]   cnt_next;
    logic           last_tick;
    logic           wake;
    logic           irq_q;

    assign tc_eff    = (tc == '0) ? {{(TCW-1){1'b0}}, 1'b1} : tc;
    assign cnt_next  = {1'b0, cnt_q} + 1'b1;
    assign last_tick = tick && (cnt_next >= {1'b0, tc_eff});

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && enable) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (stop)                     state_d = ST_FROZEN;
                else if (en_clear || lost)    state_d = ST_IDLE;
                else if (last_tick)           state_d = ST_IDLE;
            end
            ST_FROZEN: begin
                if (!stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state_q != ST_IDLE);
        in_prog = (state_q == ST_PROG);
        accept  = (state_q == ST_IDLE) && cmd_valid && enable;
        commit  = in_prog && !stop && !en_clear && !lost && last_tick;
        wake    = (state_q == ST_FROZEN) && !stop;
    end

    // datapath: tick counter, latched command, interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= commit || wake;
            if (accept) begin
                cnt_q    <= '0;
                tgt_addr <= cmd_addr;
                tgt_data <= cmd_data;
            end else if (in_prog && tick) begin
                cnt_q <= cnt_next[TCW-1:0];
            end
        end
    end

    assign done_irq = irq_q;

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          inv_en,
    input  logic [AW-1:0] inv_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    cells [DEPTH];
    logic [DEPTH-1:0] ok_q;

    // contents survive reset, as a nonvolatile store does
    always_ff @(posedge clk) begin
        if (inv_en) ok_q[inv_addr] <= 1'b0;
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
            ok_q[wr_addr]  <= 1'b1;
        end
    end

    assign rd_data  = cells[rd_addr];
    assign rd_valid = ok_q[rd_addr];

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int TCW = 16,
    parameter int WDW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_we,
    input  logic           ctl_en,
    output logic [1:0]     ctl_rdata,
    input  logic           cmd_valid,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [DW-1:0]  cmd_data,
    input  logic [1:0]     cnt_src,
    input  logic [TCW-1:0] prog_tc,
    input  logic [WDW-1:0] wdog_win,
    input  logic           main_tick,
    input  logic           timer_tick,
    input  logic           timer_run,
    input  logic           timer_oe,
    input  logic           sub_tick,
    input  logic [1:0]     pwr_state,
    output logic           done_irq,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid
);
    logic          enable_q;
    logic          busy;
    logic          in_prog;
    logic          accept;
    logic          commit;
    logic          cnt_tick;
    logic          clk_lost;
    logic          stop_req;
    logic          en_clear;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;

    always_ff @(posedge clk) begin
        if (!rst_n)      enable_q <= 1'b0;
        else if (ctl_we) enable_q <= ctl_en;
    end

    assign en_clear  = ctl_we && !ctl_en;
    assign stop_req  = (pwr_state == PWR_STOP);
    assign ctl_rdata = {busy, enable_q};

    nvm_tick_guard #(.WDW(WDW)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (in_prog),
        .src        (cnt_src),
        .main_tick  (main_tick),
        .timer_tick (timer_tick),
        .timer_run  (timer_run),
        .timer_oe   (timer_oe),
        .sub_tick   (sub_tick),
        .wdog_win   (wdog_win),
        .tick       (cnt_tick),
        .lost       (clk_lost)
    );

    nvm_prog_fsm #(.AW(AW), .DW(DW), .TCW(TCW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable_q),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .en_clear  (en_clear),
        .tick      (cnt_tick),
        .lost      (clk_lost),
        .stop      (stop_req),
        .tc        (prog_tc),
        .busy      (busy),
        .in_prog   (in_prog),
        .done_irq  (done_irq),
        .accept    (accept),
        .commit    (commit),
        .tgt_addr  (tgt_addr),
        .tgt_data  (tgt_data)
    );

    nvm_cell_array #(.AW(AW), .DW(DW)) u_cells (
        .clk      (clk),
        .inv_en   (accept),
        .inv_addr (cmd_addr),
        .wr_en    (commit),
        .wr_addr  (tgt_addr),
        .wr_data  (tgt_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/nvm_prog_checker.sv
module nvm_prog_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          irq,
    input logic          enable,
    input logic          cmd_valid,
    input logic          in_prog,
    input logic [AW-1:0] tgt_addr,
    input logic [1:0]    sel,
    input logic          timer_run,
    input logic          timer_oe,
    input logic [1:0]    pwr_state,
    input logic          ctl_we,
    input logic          ctl_en
);
    p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_follows_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(busy));

    p_accept_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(enable) && $past(cmd_valid)));

    p_target_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tgt_addr));

    p_stop_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && pwr_state == 2'd2) |=> (busy && !irq));

    p_enable_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && ctl_we && !ctl_en && pwr_state != 2'd2) |=> (!busy && !irq));

    p_timer_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && sel == 2'd1 && !(timer_run && timer_oe) && pwr_state != 2'd2)
        |=> (!busy && !irq));

endmodule

bind nvm_prog_ctrl nvm_prog_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (done_irq),
    .enable    (enable_q),
    .cmd_valid (cmd_valid),
    .in_prog   (in_prog),
    .tgt_addr  (tgt_addr),
    .sel       (cnt_src),
    .timer_run (timer_run),
    .timer_oe  (timer_oe),
    .pwr_state (pwr_state),
    .ctl_we    (ctl_we),
    .ctl_en    (ctl_en)
);

// File: tb/test_nvm_prog_ctrl.sv
module test_nvm_prog_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ctl_en = 1'b0;
    logic [1:0]  ctl_rdata;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [1:0]  cnt_src = 2'd0;
    logic [15:0] prog_tc = 16'd4;
    logic [11:0] wdog_win = 12'd8;
    logic        main_tick = 1'b0;
    logic        timer_tick = 1'b0;
    logic        timer_run = 1'b1;
    logic        timer_oe = 1'b1;
    logic        sub_tick = 1'b0;
    logic [1:0]  pwr_state = 2'd0;
    logic        done_irq;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int n_checks = 0;
    int n_err = 0;
    bit main_on = 1'b1, timer_on = 1'b1, sub_on = 1'b1;

    typedef struct {
        bit         probe;
        logic [3:0] addr;
        logic [7:0] data;
        bit         valid;
        bit         irq;
        int         ticks;
        string      req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    nvm_prog_ctrl i_nvm_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
        .ctl_rdata(ctl_rdata), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cnt_src(cnt_src), .prog_tc(prog_tc),
        .wdog_win(wdog_win), .main_tick(main_tick), .timer_tick(timer_tick),
        .timer_run(timer_run), .timer_oe(timer_oe), .sub_tick(sub_tick),
        .pwr_state(pwr_state), .done_irq(done_irq), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    // count strobes, driven on the falling edge
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            main_tick  = main_on  && (ph % 3 == 0);
            timer_tick = timer_on && (ph % 4 == 1);
            sub_tick   = sub_on   && (ph % 5 == 2);
        end
    end

    // monitor: pops expectations as cycles end
    initial begin
        bit prev = 1'b0;
        int ticks = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (ctl_rdata[1] && !prev) begin
                ticks = 0;
                if (q.size() == 0) begin
                    check(1'b0, "R3", "unexpected start", 1, 0);
                end else begin
                    rd_addr = q[0].addr;
                    #1;
                    check(rd_valid == 1'b0, "R5", "valid during cycle", rd_valid, 0);
                end
            end else if (!ctl_rdata[1] && prev) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3", "unexpected end", 1, 0);
                end else begin
                    e = q.pop_front();
                    rd_addr = e.addr;
                    #1;
                    check(done_irq == e.irq, e.req, "irq at end", done_irq, e.irq);
                    check(rd_valid == e.valid, e.req, "valid at end", rd_valid, e.valid);
                    if (e.valid)
                        check(rd_data == e.data, e.req, "data", rd_data, e.data);
                    if (e.ticks >= 0)
                        check(ticks == e.ticks, "R6", "tick count", ticks, e.ticks);
                end
            end else if (!ctl_rdata[1] && q.size() > 0 && q[0].probe) begin
                e = q.pop_front();
                rd_addr = e.addr;
                #1;
                check(rd_valid == e.valid, e.req, "probe valid", rd_valid, e.valid);
                check(rd_data == e.data, e.req, "probe data", rd_data, e.data);
            end
            if (ctl_rdata[1]) begin
                if ((cnt_src == 2'd0 && main_tick) || (cnt_src == 2'd1 && timer_tick) ||
                    (cnt_src == 2'd2 && sub_tick))
                    ticks++;
            end
            prev = ctl_rdata[1];
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 1, 0);
        summary();
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_enable(bit v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_en = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic issue(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_end(logic [3:0] a, logic [7:0] d, bit v, bit irq,
                              int t, string req);
        exp_t e;
        e.probe = 1'b0; e.addr = a; e.data = d; e.valid = v;
        e.irq = irq; e.ticks = t; e.req = req;
        q.push_back(e);
    endtask

    task automatic probe(logic [3:0] a, logic [7:0] d, string req);
        exp_t e;
        e.probe = 1'b1; e.addr = a; e.data = d; e.valid = 1'b1;
        e.irq = 1'b0; e.ticks = -1; e.req = req;
        q.push_back(e);
        cycles(3);
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            #3;
        end while (ctl_rdata[1]);
        cycles(2);
    endtask

    task automatic good_write(logic [3:0] a, logic [7:0] d, string req);
        int t;
        t = (prog_tc == 0) ? 1 : int'(prog_tc);
        expect_end(a, d, 1'b1, 1'b1, t, req);
        issue(a, d);
        wait_idle();
    endtask

    task automatic disturbed(logic [3:0] a, bit irq, string req);
        expect_end(a, 8'h00, 1'b0, irq, -1, req);
        issue(a, 8'hEE);
        cycles(3);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        #3;
        check(ctl_rdata == 2'b00, "R1", "rdata after reset", ctl_rdata, 0);
        check(done_irq == 1'b0, "R1", "irq after reset", done_irq, 0);

        set_enable(1'b1);
        #3;
        check(ctl_rdata == 2'b01, "R2", "enable readback", ctl_rdata, 1);

        // R5 R6 R7 normal writes from the main source
        good_write(4'd1, 8'hA1, "R5");
        good_write(4'd2, 8'h5A, "R7");

        // R4 overlapping command
        expect_end(4'd3, 8'hC3, 1'b1, 1'b1, 4, "R4");
        issue(4'd3, 8'hC3);
        cycles(2);
        issue(4'd2, 8'hFF);
        wait_idle();
        probe(4'd2, 8'h5A, "R4");

        // R6 terminal count of zero behaves as one
        prog_tc = 16'd0;
        good_write(4'd4, 8'h44, "R6");
        prog_tc = 16'd4;

        // R8 halt mid-cycle
        expect_end(4'd5, 8'h55, 1'b1, 1'b1, 4, "R8");
        issue(4'd5, 8'h55);
        cycles(2);
        pwr_state = 2'd1;
        wait_idle();
        pwr_state = 2'd0;

        // R7 timer source, then R11 timer stop and output disable
        cnt_src = 2'd1;
        good_write(4'd6, 8'h66, "R7");
        disturbed(4'd6, 1'b0, "R11");
        timer_run = 1'b0;
        wait_idle();
        timer_run = 1'b1;
        disturbed(4'd7, 1'b0, "R11");
        timer_oe = 1'b0;
        wait_idle();
        timer_oe = 1'b1;

        // R7 subsystem source, then R12 silent clock
        cnt_src = 2'd2;
        good_write(4'd8, 8'h88, "R7");
        disturbed(4'd9, 1'b0, "R12");
        sub_on = 1'b0;
        wait_idle();
        sub_on = 1'b1;

        // R7 empty source aborts through R12
        cnt_src = 2'd3;
        disturbed(4'd10, 1'b0, "R12");
        wait_idle();
        cnt_src = 2'd0;

        // R10 enable clear mid-cycle
        disturbed(4'd11, 1'b0, "R10");
        set_enable(1'b0);
        wait_idle();
        #1;
        check(ctl_rdata == 2'b00, "R10", "rdata after abort", ctl_rdata, 0);

        // R3 command while disabled is refused
        issue(4'd1, 8'h00);
        cycles(2);
        #3;
        check(ctl_rdata[1] == 1'b0, "R3", "busy when disabled", ctl_rdata[1], 0);
        probe(4'd1, 8'hA1, "R3");
        set_enable(1'b1);

        // R9 stop mid-cycle
        disturbed(4'd12, 1'b1, "R9");
        pwr_state = 2'd2;
        cycles(10);
        #3;
        check(ctl_rdata[1] == 1'b1, "R9", "busy while stopped", ctl_rdata[1], 1);
        check(done_irq == 1'b0, "R9", "irq while stopped", done_irq, 0);
        pwr_state = 2'd0;
        wait_idle();

        // R13 reset mid-cycle
        disturbed(4'd13, 1'b0, "R13");
        rst_n = 1'b0;
        cycles(1);
        rst_n = 1'b1;
        cycles(2);
        #3;
        check(ctl_rdata == 2'b00, "R13", "rdata after reset abort", ctl_rdata, 0);
        set_enable(1'b1);
        good_write(4'd13, 8'hD3, "R13");

        cycles(4);
        check(q.size() == 0, "R3", "pending expectations", q.size(), 0);
        summary();
    end

endmodule